// File: doc/BRIEF.md
# Deferred Arithmetic Flag Evaluator

This unit keeps the inputs and output of the most recent add or subtract instead of a flags register. Condition flags are worked out from that stored record only when they are read. A capture strobe latches the result, both operands, the operation kind and the operand width (8, 16 or 32 bits). From then on the query outputs give zero, sign, parity, carry, auxiliary-carry and overflow flags. Each is derived combinationally from the stored values with compares and XOR terms.

A packed 32-bit flag word is also provided. It carries the six arithmetic flags and a direction flag that is held apart from the deferred record. A load strobe puts a packed word back into the unit. The loaded flags then take the place of the deferred ones until the next capture. A separate strobe writes the direction flag on its own. The ALU that makes the results is outside this unit.

Top module: `lazyFlagUnit`

## Requirements
- R1: After reset the deferred record is all zeros, at 8-bit width, in add mode, with the direction flag clear. The flag word therefore reads 0x0000000A (zero and parity set).
- R2: The zero flag is 1 exactly when the stored result, masked to the operation width, is zero.
- R3: The sign flag is the top bit of the stored result at the operation width. Width codes: 0 = 8 bits, 1 = 16 bits, 2 and 3 = 32 bits.
- R4: The parity flag is 1 when the low 8 bits of the stored result hold an even number of ones.
- R5: With capSub = 0 (add), carry is 1 when the masked result is below the masked first operand. With capSub = 1 (subtract), carry is 1 when the masked first operand is below the masked second operand. Both compares are unsigned.
- R6: The auxiliary-carry flag is bit 4 of (opA XOR opB XOR result).
- R7: For a subtract, overflow is the width's top bit of ((opA XOR opB) AND (opA XOR result)). For an add, opB is inverted in that expression.
- R8: Flag word layout from bit 0 upward: carry, parity, aux-carry, zero, sign, overflow, direction. Bits 31..7 are always zero.
- R9: A load copies loadWord bits 5..0 into the six flags and bit 6 into the direction flag, and ignores bits 31..7. The loaded flags are reported until the next capture.
- R10: A capture wins over a load in the same cycle, and that load then has no effect. A capture never changes the direction flag.
- R11: A direction write sets the direction flag from dirValue. It wins over the bit 6 of a load in the same cycle.
- R12: All outputs reflect a strobe from the first clock edge after it. With no strobe, they stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capValid | input | 1 | Capture strobe for the operation record |
| capSub | input | 1 | 1 = subtract, 0 = add |
| capWidth | input | 2 | Operand width code |
| capResult | input | 32 | Operation result |
| capOpA | input | 32 | First operand |
| capOpB | input | 32 | Second operand |
| loadValid | input | 1 | Load strobe for a packed flag word |
| loadWord | input | 32 | Packed flag word to restore |
| dirWrite | input | 1 | Direction flag write strobe |
| dirValue | input | 1 | New direction flag value |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| af | output | 1 | Auxiliary-carry flag |
| of | output | 1 | Overflow flag |
| df | output | 1 | Direction flag |
| flagWord | output | 32 | Packed flags |

## Verification
Each strobe is stored on one clock edge, and every output is a combinational function of that stored state. So any capture, load or direction write is due right after the next rising edge. The bench drives every strobe on a falling edge and samples on the following falling edge, one edge after the update and half a period clear of it. Idle cycles are sampled the same way to show that nothing moves without a strobe.

// File: rtl/lazyflag_pkg.sv
package lazyflag_pkg;
  // bit positions inside the packed flag word
  localparam int POS_CF = 0;
  localparam int POS_PF = 1;
  localparam int POS_AF = 2;
  localparam int POS_ZF = 3;
  localparam int POS_SF = 4;
  localparam int POS_OF = 5;
  localparam int POS_DF = 6;
  localparam int ARITH_FLAGS = 6;

  typedef struct packed {
    logic captureEn;
    logic loadEn;
    logic dirEn;
    logic useLoaded;
  } flagStrobes_t;
endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import lazyflag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         capValid,
  input  logic         loadValid,
  input  logic         dirWrite,
  output flagStrobes_t strobes
);
  logic loadedMode;

  always_ff @(posedge clk) begin
    if (!rstN)              loadedMode <= 1'b0;
    else if (capValid)      loadedMode <= 1'b0;
    else if (loadValid)     loadedMode <= 1'b1;
  end

  always_comb begin
    strobes.captureEn = capValid;
    strobes.loadEn    = loadValid && !capValid;
    strobes.dirEn     = dirWrite;
    strobes.useLoaded = loadedMode;
  end

  // R10
  capture_clears_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    capValid |=> !loadedMode);
  // R9
  load_sets_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !capValid) |=> loadedMode);
endmodule

// File: rtl/flagData.sv
module flagData
  import lazyflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 32,
  parameter int NUM_W  = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strobes,
  input  logic              capSub,
  input  logic [1:0]        capWidth,
  input  logic [DATA_W-1:0] capResult,
  input  logic [DATA_W-1:0] capOpA,
  input  logic [DATA_W-1:0] capOpB,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              dirValue,
  output logic              zf,
  output logic              sf,
  output logic              pf,
  output logic              cf,
  output logic              af,
  output logic              of,
  output logic              df,
  output logic [WORD_W-1:0] flagWord
);
  localparam int SEL_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
  localparam int PACK_W = ARITH_FLAGS + 1;

  logic [DATA_W-1:0]      resReg, opAReg, opBReg;
  logic                   subReg;
  logic [SEL_W-1:0]       selReg, selNext;
  logic [ARITH_FLAGS-1:0] savedFlags;
  logic                   dfReg;

  always_comb begin
    if (int'(capWidth) >= NUM_W) selNext = SEL_W'(NUM_W - 1);
    else                         selNext = SEL_W'(capWidth);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg <= '0;
      opAReg <= '0;
      opBReg <= '0;
      subReg <= 1'b0;
      selReg <= '0;
    end else if (strobes.captureEn) begin
      resReg <= capResult;
      opAReg <= capOpA;
      opBReg <= capOpB;
      subReg <= capSub;
      selReg <= selNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               savedFlags <= '0;
    else if (strobes.loadEn) savedFlags <= loadWord[ARITH_FLAGS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dfReg <= 1'b0;
    else if (strobes.dirEn)  dfReg <= dirValue;
    else if (strobes.loadEn) dfReg <= loadWord[POS_DF];
  end

  // per-width flag terms
  logic [NUM_W-1:0] zfV, sfV, cfV, ofV;
  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int W = 8 << g;
    logic [W-1:0] rW, aW, bW, bAdj, ovfTerm;
    assign rW      = resReg[W-1:0];
    assign aW      = opAReg[W-1:0];
    assign bW      = opBReg[W-1:0];
    assign bAdj    = subReg ? bW : ~bW;
    assign ovfTerm = (aW ^ bAdj) & (aW ^ rW);
    assign zfV[g]  = (rW == '0);
    assign sfV[g]  = rW[W-1];
    assign cfV[g]  = subReg ? (aW < bW) : (rW < aW);
    assign ofV[g]  = ovfTerm[W-1];
  end

  logic [DATA_W-1:0]      halfTerm;
  logic [ARITH_FLAGS-1:0] lazyFlags, activeFlags;

  always_comb begin
    halfTerm = opAReg ^ opBReg ^ resReg;
    lazyFlags = '0;
    lazyFlags[POS_CF] = cfV[selReg];
    lazyFlags[POS_PF] = ~^resReg[7:0];
    lazyFlags[POS_AF] = halfTerm[4];
    lazyFlags[POS_ZF] = zfV[selReg];
    lazyFlags[POS_SF] = sfV[selReg];
    lazyFlags[POS_OF] = ofV[selReg];
    activeFlags = strobes.useLoaded ? savedFlags : lazyFlags;
  end

  assign cf = activeFlags[POS_CF];
  assign pf = activeFlags[POS_PF];
  assign af = activeFlags[POS_AF];
  assign zf = activeFlags[POS_ZF];
  assign sf = activeFlags[POS_SF];
  assign of = activeFlags[POS_OF];
  assign df = dfReg;
  assign flagWord = WORD_W'({dfReg, activeFlags});

  // R2
  zero_after_byte_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureEn && capWidth == 2'd0) |=> (zf == ($past(capResult[7:0]) == 8'h00)));
  // R9
  load_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> (flagWord[ARITH_FLAGS-1:0] == $past(loadWord[ARITH_FLAGS-1:0])));
  // R11
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dirEn |=> (df == $past(dirValue)));
  // R10
  df_keep_on_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureEn && !strobes.dirEn) |=> $stable(df));
  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.captureEn && !strobes.loadEn && !strobes.dirEn) |=> $stable(flagWord));
  // R4
  parity_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> (pf == ~^$past(capResult[7:0])));
endmodule

// File: rtl/lazyFlagUnit.sv
module lazyFlagUnit
  import lazyflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic              capSub,
  input  logic [1:0]        capWidth,
  input  logic [DATA_W-1:0] capResult,
  input  logic [DATA_W-1:0] capOpA,
  input  logic [DATA_W-1:0] capOpB,
  input  logic              loadValid,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              dirWrite,
  input  logic              dirValue,
  output logic              zf,
  output logic              sf,
  output logic              pf,
  output logic              cf,
  output logic              af,
  output logic              of,
  output logic              df,
  output logic [WORD_W-1:0] flagWord
);
  flagStrobes_t strobes;

  flagCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .capValid(capValid), .loadValid(loadValid),
    .dirWrite(dirWrite), .strobes(strobes)
  );

  flagData #(.DATA_W(DATA_W), .WORD_W(WORD_W), .NUM_W(3)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .capSub(capSub),
    .capWidth(capWidth), .capResult(capResult), .capOpA(capOpA), .capOpB(capOpB),
    .loadWord(loadWord), .dirValue(dirValue),
    .zf(zf), .sf(sf), .pf(pf), .cf(cf), .af(af), .of(of), .df(df),
    .flagWord(flagWord)
  );
endmodule

// File: tb/test_lazyFlagUnit.sv
`timescale 1ns/1ps
module test_lazyFlagUnit;
  logic clk = 1'b0;
  logic rstN;
  logic capValid, capSub, loadValid, dirWrite, dirValue;
  logic [1:0] capWidth;
  logic [31:0] capResult, capOpA, capOpB, loadWord;
  logic zf, sf, pf, cf, af, of, df;
  logic [31:0] flagWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic mLoaded;
  logic [5:0] mSaved, mCap;
  logic mDf;

  always #2.5 clk = ~clk;

  lazyFlagUnit i_lazyFlagUnit (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capSub(capSub),
    .capWidth(capWidth), .capResult(capResult), .capOpA(capOpA), .capOpB(capOpB),
    .loadValid(loadValid), .loadWord(loadWord), .dirWrite(dirWrite),
    .dirValue(dirValue), .zf(zf), .sf(sf), .pf(pf), .cf(cf), .af(af), .of(of),
    .df(df), .flagWord(flagWord)
  );

  // order {OF,SF,ZF,AF,PF,CF}
  function automatic logic [5:0] refFlags(input logic sub, input logic [1:0] w,
      input logic [31:0] res, input logic [31:0] a, input logic [31:0] b);
    int n;
    logic [31:0] m, r, aa, bb, x, t;
    logic c, s, z, p, h, o;
    n = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    r = res & m; aa = a & m; bb = b & m;
    c = sub ? (aa < bb) : (r < aa);
    s = r[n-1];
    z = (r == 32'd0);
    p = ~^r[7:0];
    x = a ^ b ^ res;
    h = x[4];
    t = sub ? ((aa ^ bb) & (aa ^ r)) : ((aa ^ ~bb) & (aa ^ r));
    o = t[n-1];
    return {o, s, z, h, p, c};
  endfunction

  function automatic logic [31:0] expWord();
    return {25'd0, mDf, (mLoaded ? mSaved : mCap)};
  endfunction

  task automatic check(input string tag);
    logic [31:0] e;
    e = expWord();
    checks++;
    if (flagWord !== e) begin
      errors++;
      $display("FAIL %s flagWord actual=%h expected=%h", tag, flagWord, e);
    end
    checks++;
    if ({df, of, sf, zf, af, pf, cf} !== e[6:0]) begin
      errors++;
      $display("FAIL %s flag pins actual=%b expected=%b", tag,
               {df, of, sf, zf, af, pf, cf}, e[6:0]);
    end
  endtask

  task automatic step(input logic cap, input logic sub, input logic [1:0] w,
      input logic [31:0] res, input logic [31:0] a, input logic [31:0] b,
      input logic ld, input logic [31:0] lw, input logic dw, input logic dv,
      input string tag);
    @(negedge clk);
    capValid = cap; capSub = sub; capWidth = w; capResult = res;
    capOpA = a; capOpB = b; loadValid = ld; loadWord = lw;
    dirWrite = dw; dirValue = dv;
    if (cap) begin
      mCap = refFlags(sub, w, res, a, b);
      mLoaded = 1'b0;
    end else if (ld) begin
      mSaved = lw[5:0];
      mLoaded = 1'b1;
      if (!dw) mDf = lw[6];
    end
    if (dw) mDf = dv;
    @(negedge clk);
    capValid = 0; loadValid = 0; dirWrite = 0;
    check(tag);
  endtask

  task automatic capOp(input logic sub, input logic [1:0] w,
      input logic [31:0] res, input logic [31:0] a, input logic [31:0] b,
      input string tag);
    step(1, sub, w, res, a, b, 0, 32'd0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; capValid = 0; capSub = 0; capWidth = 0; capResult = 0;
    capOpA = 0; capOpB = 0; loadValid = 0; loadWord = 0; dirWrite = 0; dirValue = 0;
    mLoaded = 0; mSaved = 0; mCap = 6'b001010; mDf = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (flagWord !== 32'h0000_000A) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", flagWord, 32'h0000_000A);
    end
    // R2 R5 R6 byte add wrapping to zero: expect word 0x0F
    capOp(0, 2'd0, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0001, "R2 R5 R6 byte carry");
    checks++;
    if (flagWord !== 32'h0000_000F) begin
      errors++;
      $display("FAIL R2 literal actual=%h expected=%h", flagWord, 32'h0000_000F);
    end
    // R7 R4 byte subtract overflow: expect 0x24
    capOp(1, 2'd0, 32'h0000_007F, 32'h0000_0080, 32'h0000_0001, "R7 R4 byte sub overflow");
    checks++;
    if (flagWord !== 32'h0000_0024) begin
      errors++;
      $display("FAIL R7 literal actual=%h expected=%h", flagWord, 32'h0000_0024);
    end
    // R3 width codes
    capOp(0, 2'd1, 32'h0001_8000, 32'h0000_7FFF, 32'h0001_0001, "R3 half sign");
    capOp(0, 2'd3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, "R3 code3 as word");
    capOp(0, 2'd2, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, "R7 word add overflow");
    // R5 subtract borrow at 16 bits
    capOp(1, 2'd1, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0001, "R5 half borrow");
    // R9 load with upper bits set; R8 layout
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFA5, 0, 0, "R9 R8 load");
    checks++;
    if (flagWord !== 32'h0000_0025) begin
      errors++;
      $display("FAIL R8 literal actual=%h expected=%h", flagWord, 32'h0000_0025);
    end
    // R12 idle hold
    step(0, 0, 0, 0, 0, 0, 0, 32'd0, 0, 0, "R12 idle hold");
    // R11 direction write wins over load bit 6
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0040, 1, 0, "R11 dir over load");
    step(0, 0, 0, 0, 0, 0, 0, 32'd0, 1, 1, "R11 dir set");
    // R10 capture beats load, DF unchanged
    step(1, 1, 2'd0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0010, 1, 32'h0000_003F, 0, 0,
         "R10 capture beats load");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b, r, lw;
      logic sub, cap, ld, dw, dv;
      logic [1:0] w;
      int k;
      a = $urandom; b = $urandom; sub = 1'($urandom); w = 2'($urandom);
      if (($urandom % 4) == 0) begin a = a & 32'hFF; b = b & 32'h1FF; end
      r = sub ? (a - b) : (a + b);
      if (($urandom % 4) == 0) r = $urandom;
      if (($urandom % 8) == 0) r = 32'd0;
      k = $urandom % 10;
      cap = (k < 6) || (k == 9);
      ld = (k >= 6);
      dw = (($urandom % 6) == 0);
      dv = 1'($urandom);
      lw = $urandom;
      if (k == 8) begin cap = 0; ld = 0; end
      step(cap, sub, w, r, a, b, ld, lw, dw, dv, "R12 random mix");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule